// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Unit

This block multiplies a stream of signed 8-bit input vectors by an N x N signed 8-bit weight matrix held inside a square grid of multiply-accumulate cells. A weight matrix is first shifted into the grid, one row per cycle. It then stays in place for any number of later batches. Input vectors enter at one edge of the grid, one vector per cycle. Element k of a vector is delayed by k cycles, so each element meets its weights as the running sums pass down each column.

The column sums leave the bottom of the grid. Each column is then delayed so that a whole result row lines up again. The row is written into a bank of 32-bit accumulators, at the address given by the position of the vector within its batch. Per batch, the accumulators either start from zero or add onto what they already hold. A control processor streams a batch, waits for the one-cycle completion pulse, and reads the result rows back through a combinational read port.

Top module: `ws_matrix_unit`

## Requirements
- R1: While reset is held and afterwards until the first result row is written, `done` is low and every accumulator row reads zero.
- R2: Each cycle with `wt_load` high shifts one weight row in. After N such cycles, the first row supplied multiplies input element 0 and the last row supplied multiplies element N-1. Weight for output column c sits in bits [8c+7:8c] of `wt_row`.
- R3: Column c of a result row equals the sum over k of x[k]*w[k][c]. All operands are signed two's-complement 8-bit values, and input element k sits in bits [8k+7:8k] of `in_row`. Column c of `rd_data` is 32 bits wide at bits [32c+31:32c].
- R4: A row accepted at clock edge t is visible on `rd_data` after edge t+2N-1. The m-th row of a batch (counting from 0) lands at accumulator address m. Rows accepted on consecutive cycles are written on consecutive cycles.
- R5: `acc_clear` is sampled with the first row of a batch. With 1, the rows of that batch replace the stored values. With 0, the rows are added onto them.
- R6: `done` is high for exactly one cycle, after edge t+2N-1, where t is the edge that accepted the row marked `in_last`.
- R7: A row presented with `in_valid` while `wt_load` is high is ignored. It changes no accumulator and raises no `done`.
- R8: Accumulator rows that a batch does not address keep their values.
- R9: Weights stay fixed across batches until the next load, so a second batch without reloading uses the same matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_load | input | 1 | Shift one weight row into the grid this cycle |
| wt_row | input | N*8 | Weight row being shifted in, column c in byte c |
| in_valid | input | 1 | An input vector is offered this cycle |
| in_row | input | N*8 | Input vector, element k in byte k |
| in_last | input | 1 | Marks the final vector of a batch |
| acc_clear | input | 1 | With the first vector of a batch: 1 overwrites, 0 adds |
| rd_addr | input | log2(DEPTH) | Accumulator row to read |
| rd_data | output | N*32 | Accumulator row contents, column c in word c |
| done | output | 1 | One-cycle pulse once the batch's last row is written |

## Verification
The hardest situation to reach is a result that depends on every term at once. That requires correct skew of every input element, correct stationary weight placement, and the correct add-or-replace choice, all aligned in the same cycle. The stimulus reaches it with a batch that replaces, then a shorter batch that adds over part of the same rows without reloading, then a replacing batch, and finally a reload with a different matrix. Rows outside each batch are read back between runs. Operands of -128 meet negative weights so that the sign extension is exercised. The first-row latency is measured by holding the read address at row 0 and noting the exact cycle its value leaves zero.

// File: rtl/ws_pkg.sv
package ws_pkg;
    localparam int DATA_W = 8;
    localparam int ACC_W  = 32;
    localparam int PROD_W = 2 * DATA_W;
endpackage

// File: rtl/ws_delay.sv
module ws_delay #(
    parameter int W   = 32,
    parameter int LEN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (LEN == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            logic [W-1:0] stage_d [LEN];
            logic [W-1:0] stage_q [LEN];
            always_comb begin
                stage_d[0] = din;
                for (int i = 1; i < LEN; i++) stage_d[i] = stage_q[i-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < LEN; i++) stage_q[i] <= '0;
                end else begin
                    for (int i = 0; i < LEN; i++) stage_q[i] <= stage_d[i];
                end
            end
            assign dout = stage_q[LEN-1];
        end
    endgenerate
endmodule

// File: rtl/ws_pe.sv
module ws_pe
    import ws_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wt_shift,
    input  logic signed [DATA_W-1:0] wt_in,
    output logic signed [DATA_W-1:0] wt_out,
    input  logic signed [DATA_W-1:0] a_in,
    output logic signed [DATA_W-1:0] a_out,
    input  logic signed [ACC_W-1:0]  ps_in,
    output logic signed [ACC_W-1:0]  ps_out
);
    typedef struct packed {
        logic signed [DATA_W-1:0] w;
        logic signed [DATA_W-1:0] a;
        logic signed [ACC_W-1:0]  ps;
    } pe_t;

    pe_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod     = a_in * st_q.w;
        st_d     = st_q;
        st_d.w   = wt_shift ? wt_in : st_q.w;
        st_d.a   = a_in;
        st_d.ps  = ps_in + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wt_out = st_q.w;
    assign a_out  = st_q.a;
    assign ps_out = st_q.ps;
endmodule

// File: rtl/ws_acc_bank.sv
module ws_acc_bank
    import ws_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_clr,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [N*ACC_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]     rd_addr,
    output logic [N*ACC_W-1:0]   rd_data
);
    logic [ACC_W-1:0] acc_d [DEPTH][N];
    logic [ACC_W-1:0] acc_q [DEPTH][N];

    always_comb begin
        acc_d = acc_q;
        if (wr_en) begin
            for (int c = 0; c < N; c++) begin
                acc_d[wr_idx][c] = (wr_clr ? '0 : acc_q[wr_idx][c])
                                   + wr_data[c*ACC_W +: ACC_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++)
                for (int c = 0; c < N; c++) acc_q[r][c] <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    generate
        for (genvar c = 0; c < N; c++) begin : g_rd
            assign rd_data[c*ACC_W +: ACC_W] = acc_q[rd_addr][c];
        end
    endgenerate
endmodule

// File: rtl/ws_matrix_unit.sv
module ws_matrix_unit
    import ws_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PIPE  = 2 * N - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wt_load,
    input  logic [N*DATA_W-1:0]   wt_row,
    input  logic                  in_valid,
    input  logic [N*DATA_W-1:0]   in_row,
    input  logic                  in_last,
    input  logic                  acc_clear,
    input  logic [IDX_W-1:0]      rd_addr,
    output logic [N*ACC_W-1:0]    rd_data,
    output logic                  done
);
    typedef struct packed {
        logic             v;
        logic             last;
        logic             clr;
        logic [IDX_W-1:0] idx;
    } tag_t;

    typedef struct packed {
        logic [IDX_W-1:0] row;
        logic             clr_hold;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    tag_t tag_d [PIPE];
    tag_t tag_q [PIPE];

    logic accept;
    logic clr_now;
    assign accept  = in_valid && !wt_load;
    assign clr_now = (ctl_q.row == '0) ? acc_clear : ctl_q.clr_hold;

    // grid wiring
    logic signed [DATA_W-1:0] act [N][N+1];
    logic signed [DATA_W-1:0] wgt [N+1][N];
    logic signed [ACC_W-1:0]  ps  [N+1][N];
    logic [N*ACC_W-1:0]       res_flat;

    generate
        for (genvar r = 0; r < N; r++) begin : g_skew
            logic [DATA_W-1:0] gated;
            assign gated = accept ? in_row[r*DATA_W +: DATA_W] : '0;
            ws_delay #(.W(DATA_W), .LEN(r)) u_skew (
                .clk(clk), .rst_n(rst_n), .din(gated), .dout(act[r][0])
            );
        end
        for (genvar c = 0; c < N; c++) begin : g_edge
            assign wgt[N][c] = wt_row[c*DATA_W +: DATA_W];
            assign ps[0][c]  = '0;
        end
        for (genvar r = 0; r < N; r++) begin : g_row
            for (genvar c = 0; c < N; c++) begin : g_col
                ws_pe u_pe (
                    .clk(clk), .rst_n(rst_n), .wt_shift(wt_load),
                    .wt_in(wgt[r+1][c]), .wt_out(wgt[r][c]),
                    .a_in(act[r][c]), .a_out(act[r][c+1]),
                    .ps_in(ps[r][c]), .ps_out(ps[r+1][c])
                );
            end
        end
        for (genvar c = 0; c < N; c++) begin : g_deskew
            ws_delay #(.W(ACC_W), .LEN(N - 1 - c)) u_deskew (
                .clk(clk), .rst_n(rst_n), .din(ps[N][c]),
                .dout(res_flat[c*ACC_W +: ACC_W])
            );
        end
    endgenerate

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.row      = in_last ? '0 : ctl_q.row + 1'b1;
            ctl_d.clr_hold = clr_now;
        end
        ctl_d.done = tag_q[PIPE-1].v && tag_q[PIPE-1].last;
        tag_d[0] = '{v: accept, last: in_last, clr: clr_now, idx: ctl_q.row};
        for (int i = 1; i < PIPE; i++) tag_d[i] = tag_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < PIPE; i++) tag_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < PIPE; i++) tag_q[i] <= tag_d[i];
        end
    end

    ws_acc_bank #(.N(N), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tag_q[PIPE-1].v), .wr_clr(tag_q[PIPE-1].clr),
        .wr_idx(tag_q[PIPE-1].idx), .wr_data(res_flat),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign done = ctl_q.done;
endmodule

// File: rtl/ws_matrix_unit_chk.sv
module ws_matrix_unit_chk
    import ws_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int LAT   = 2 * N
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wt_load,
    input logic [N*DATA_W-1:0] wt_row,
    input logic                in_valid,
    input logic [N*DATA_W-1:0] in_row,
    input logic                in_last,
    input logic                acc_clear,
    input logic [IDX_W-1:0]    rd_addr,
    input logic [N*ACC_W-1:0]  rd_data,
    input logic                done
);
    typedef struct packed {
        logic             v;
        logic             last;
        logic [IDX_W-1:0] idx;
    } obs_t;

    obs_t             obs_q [LAT];
    logic [IDX_W-1:0] cnt_q;
    logic             ever_q;
    logic             take;
    assign take = in_valid && !wt_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) obs_q[i] <= '0;
            cnt_q  <= '0;
            ever_q <= 1'b0;
        end else begin
            obs_q[0] <= '{v: take, last: take && in_last, idx: cnt_q};
            for (int i = 1; i < LAT; i++) obs_q[i] <= obs_q[i-1];
            if (take) cnt_q <= in_last ? '0 : cnt_q + 1'b1;
            if (obs_q[LAT-1].v) ever_q <= 1'b1;
        end
    end

    // R6: completion pulse lines up with the final accepted row
    assert_done_timing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done == obs_q[LAT-1].last);

    // R8 and R7: a row not written at the last edge reads back unchanged
    assert_rows_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(obs_q[LAT-1].v && obs_q[LAT-1].idx == rd_addr) && $stable(rd_addr))
        |-> $stable(rd_data));

    // R1: nothing but zero before the first write
    assert_zero_before_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(ever_q || obs_q[LAT-1].v) |-> rd_data == '0);

    // R1: reset holds the pulse low
    always_ff @(posedge clk) begin
        if (!rst_n) assert_reset_idle_R1: assert (!done);
    end
endmodule

bind ws_matrix_unit ws_matrix_unit_chk #(.N(N), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/ws_matrix_unit_tb.sv
`timescale 1ns/1ps
module ws_matrix_unit_tb;
    localparam int N     = 4;
    localparam int DEPTH = 8;
    localparam int LAT   = 2 * N - 1;

    localparam logic [31:0] STIM [8] = '{
        32'h04030201, 32'hFF80017F, 32'h80808080, 32'h00000000,
        32'h10F00AF6, 32'h7F7F7F7F, 32'h01FE03FD, 32'hC0204080
    };
    localparam logic [31:0] WA [4] = '{32'h80_02_FF_01, 32'h05_80_03_03,
                                       32'hFE_7F_00_80, 32'h01_04_FC_02};
    localparam logic [31:0] WB [4] = '{32'h01_00_00_7F, 32'h00_01_80_00,
                                       32'h00_80_01_00, 32'h7F_00_00_01};

    logic clk = 0, rst_n = 0;
    logic wt_load = 0, in_valid = 0, in_last = 0, acc_clear = 0;
    logic [N*8-1:0] wt_row = '0, in_row = '0;
    logic [2:0] rd_addr = '0;
    logic [N*32-1:0] rd_data;
    logic done;

    ws_matrix_unit #(.N(N), .DEPTH(DEPTH)) u_dut (.*);

    always #2 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int done_cnt = 0, done_cyc = -1, lat_cyc = -1;
    bit watch0 = 0;
    int mdl [DEPTH][N];
    int wsel = 0;

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) begin
        if (rst_n && done) begin done_cnt++; done_cyc = cyc; end
        if (watch0 && lat_cyc < 0 && rd_data != '0) lat_cyc = cyc;
    end

    function automatic int wbyte(int k, int c);
        logic [31:0] r;
        r = (wsel == 0) ? WA[k] : WB[k];
        return int'($signed(r[c*8 +: 8]));
    endfunction

    function automatic int dotp(logic [31:0] x, int c);
        int s = 0;
        for (int k = 0; k < N; k++) s += int'($signed(x[k*8 +: 8])) * wbyte(k, c);
        return s;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_row(string req, int r);
        logic [127:0] e;
        for (int c = 0; c < N; c++) e[c*32 +: 32] = mdl[r][c];
        @(negedge clk); rd_addr = 3'(r); #1;
        check(req, rd_data, e);
    endtask

    task automatic load_weights(int sel, bit noise);
        wsel = sel;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            wt_load = 1; wt_row = (sel == 0) ? WA[k] : WB[k];
            in_valid = noise; in_row = 32'h7F7F7F7F; in_last = noise;
        end
        @(negedge clk); wt_load = 0; in_valid = 0; in_last = 0;
    endtask

    // streams table rows [first, first+cnt) as one batch; returns edge of last accept
    task automatic run_batch(int first, int cnt, bit clr, output int last_edge, output int first_edge);
        done_cnt = 0; done_cyc = -1;
        for (int m = 0; m < cnt; m++) begin
            @(negedge clk);
            in_valid = 1; in_row = STIM[(first + m) % 8];
            in_last = (m == cnt - 1); acc_clear = clr;
            if (m == 0) first_edge = cyc + 1;
            last_edge = cyc + 1;
            for (int c = 0; c < N; c++)
                mdl[m][c] = (clr ? 0 : mdl[m][c]) + dotp(in_row, c);
        end
        @(negedge clk); in_valid = 0; in_last = 0; acc_clear = 0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int le, fe;
        for (int r = 0; r < DEPTH; r++) for (int c = 0; c < N; c++) mdl[r][c] = 0;
        repeat (3) @(negedge clk);
        check("R1 done in reset", 128'(done), 128'(0));
        rst_n = 1;
        @(negedge clk);
        for (int r = 0; r < DEPTH; r++) check_row("R1 zero after reset", r);

        // R7: rows offered during the weight load must be dropped
        done_cnt = 0;
        load_weights(0, 1);
        repeat (LAT + 3) @(negedge clk);
        check("R7 no done from blocked rows", 128'(done_cnt), 128'(0));
        for (int r = 0; r < DEPTH; r++) check_row("R7 rows untouched by blocked input", r);

        // table walk: six rows, replace mode, latency watched at row 0
        rd_addr = 0; watch0 = 1;
        run_batch(0, 6, 1, le, fe);
        watch0 = 0;
        check("R4 first row latency", 128'(lat_cyc), 128'(fe + LAT));
        check("R6 single done pulse", 128'(done_cnt), 128'(1));
        check("R6 done timing", 128'(done_cyc), 128'(le + LAT));
        for (int r = 0; r < 6; r++) check_row("R3 product row", r);
        check_row("R8 row 6 untouched", 6);
        check_row("R8 row 7 untouched", 7);

        // add mode over three rows, same weights
        run_batch(6, 3, 0, le, fe);
        check("R6 done timing add batch", 128'(done_cyc), 128'(le + LAT));
        for (int r = 0; r < 3; r++) check_row("R5 R9 accumulate row", r);
        for (int r = 3; r < 6; r++) check_row("R8 rows beyond batch kept", r);

        // replace mode over two rows
        run_batch(3, 2, 1, le, fe);
        for (int r = 0; r < 2; r++) check_row("R5 replace row", r);
        check_row("R8 row 2 kept", 2);

        // reload a different matrix
        load_weights(1, 0);
        run_batch(1, 4, 1, le, fe);
        for (int r = 0; r < 4; r++) check_row("R2 new weights row", r);

        // single-row batch, add mode
        run_batch(2, 1, 0, le, fe);
        check("R6 one-row batch pulse", 128'(done_cnt), 128'(1));
        check("R6 one-row batch timing", 128'(done_cyc), 128'(le + LAT));
        check_row("R5 single-row add", 0);
        check_row("R8 row 1 kept", 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule